// File: doc/BRIEF.md
# Power-Stage Fault Aggregator and Status Reporter

This block sits between the protection sensors of a multi-pair half-bridge power stage and the gate-drive enables. It collects global faults (over-temperature error, supply undervoltage on the gate-drive, logic and bootstrap rails, power-on reset) and per-pair faults (overload). From these it decides, for each bridge pair, whether that pair's outputs must be forced to high impedance. It also reports fault classes to a system controller on two active-low status lines: a shutdown line and an over-temperature warning line.

Analog comparators outside the block supply separate "cross into fault" and "cross back out" inputs for each hysteretic quantity, and the block holds the state between the two crossings. Undervoltage faults recover by themselves once the rail is good again. Over-temperature error and overload faults latch. Overload is cleared by a reset of the affected pair. Over-temperature error is cleared only after every pair reset has been asserted. Driving a pair reset low also hard-mutes that pair and holds the shutdown line released. The Hi-Z enables react in the same cycle as a fault input. The two status lines are registered and follow the fault state one clock later.

Top module: `fault_status_agg`

## Requirements
- R1: While `por_i` is high, every `hiz_o` bit is 1 and `sd_n_o` and `otw_n_o` are 1. After `por_i` falls, with no faults and all pair resets high, `hiz_o` is all 0 and both status lines stay 1.
- R2: `otw_n_o` goes low two clock edges after `warn_set_i` is seen. It stays low while neither comparator input is active and returns high two edges after `warn_clr_i` is seen.
- R3: `err_set_i` forces every `hiz_o` bit to 1 in the same cycle. Two edges later the status lines read `sd_n_o`=0 and `otw_n_o`=0. This state is latched after `err_set_i` drops.
- R4: The over-temperature error latch clears only once every `pair_rst_n_i` bit has been seen low since the latch was set. The resets need not be low at the same time, and a subset of them is not enough.
- R5: A set input on any gate/logic supply (`sup_uv_set_i`) or on any bootstrap rail (`bst_uv_set_i`) forces all `hiz_o` bits to 1 in the same cycle. It gives `sd_n_o`=0 and `otw_n_o`=1 two edges later. Normal operation resumes by itself once every affected rail's clear input has been seen.
- R6: An undervoltage stays in force after its set input drops, until the matching clear input is seen.
- R7: `ovl_i[p]` sets only `hiz_o[p]` and gives `sd_n_o`=0. The fault stays latched after `ovl_i[p]` drops, until `pair_rst_n_i[p]` is seen low.
- R8: `pair_rst_n_i[p]` low forces `hiz_o[p]` to 1 in the same cycle. With any pair reset low, `sd_n_o` reads 1 one edge later, whatever faults are present.
- R9: Status encoding as {`sd_n_o`,`otw_n_o`}: 00 means over-temperature error, or shutdown fault plus warning. 01 means overload or undervoltage. 10 means warning only. 11 means normal.
- R10: `por_i` clears every latched fault, including overload, with no pair reset needed.
- R11: The status lines are registered. A fault seen at one edge changes `sd_n_o` at the following edge, not at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| warn_set_i | input | 1 | Temperature above the warning threshold |
| warn_clr_i | input | 1 | Temperature below the warning release point |
| err_set_i | input | 1 | Temperature above the error threshold |
| sup_uv_set_i | input | NSUP | Gate/logic rail below its falling threshold, one bit per rail |
| sup_uv_clr_i | input | NSUP | Gate/logic rail above its rising threshold |
| bst_uv_set_i | input | NBST | Bootstrap rail below its falling threshold |
| bst_uv_clr_i | input | NBST | Bootstrap rail above its rising threshold |
| ovl_i | input | NPAIR | Overload detected in a pair |
| pair_rst_n_i | input | NPAIR | Pair reset, active low |
| hiz_o | output | NPAIR | 1 forces the pair's outputs to high impedance |
| sd_n_o | output | 1 | Shutdown status, active low |
| otw_n_o | output | 1 | Over-temperature status, active low |

## Verification
The main table walks a single long history. It checks that hysteresis holds state between set and clear, that auto-recovering undervoltage differs from the latched overload and error faults, and that an overload on one pair leaves the other pair enabled. The error-clear sequence asserts the two pair resets at different times, with a check between them. This separates "all resets seen" from "all resets low together" and from "any reset seen". Directed tests sample within a cycle and across single edges. They separate the same-cycle Hi-Z path from the registered status path, exercise the bootstrap and logic rails, and show that power-on reset clears an overload with no pair reset.

// File: rtl/fault_status_agg.sv
module fault_status_agg #(
  parameter int NPAIR = 2,
  parameter int NSUP  = 5,
  parameter int NBST  = 4
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             warn_set_i,
  input  logic             warn_clr_i,
  input  logic             err_set_i,
  input  logic [NSUP-1:0]  sup_uv_set_i,
  input  logic [NSUP-1:0]  sup_uv_clr_i,
  input  logic [NBST-1:0]  bst_uv_set_i,
  input  logic [NBST-1:0]  bst_uv_clr_i,
  input  logic [NPAIR-1:0] ovl_i,
  input  logic [NPAIR-1:0] pair_rst_n_i,
  output logic [NPAIR-1:0] hiz_o,
  output logic             sd_n_o,
  output logic             otw_n_o
);

  logic             warn_q;
  logic             ote_q;
  logic [NPAIR-1:0] rst_seen_q;
  logic [NSUP-1:0]  sup_uv_q;
  logic [NBST-1:0]  bst_uv_q;
  logic [NPAIR-1:0] ovl_q;
  logic             sd_n_q;
  logic             otw_n_q;

  logic [NPAIR-1:0] seen_now;
  logic             uv_any;
  logic             global_off;
  logic             fault_any;

  assign seen_now   = rst_seen_q | ~pair_rst_n_i;
  assign uv_any     = (|sup_uv_q) | (|bst_uv_q);
  assign global_off = por_i | ote_q | err_set_i | uv_any
                    | (|sup_uv_set_i) | (|bst_uv_set_i);
  assign fault_any  = ote_q | uv_any | (|ovl_q);

  assign hiz_o   = {NPAIR{global_off}} | ovl_q | ovl_i | ~pair_rst_n_i;
  assign sd_n_o  = sd_n_q;
  assign otw_n_o = otw_n_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      warn_q     <= 1'b0;
      ote_q      <= 1'b0;
      rst_seen_q <= '0;
      sup_uv_q   <= '0;
      bst_uv_q   <= '0;
      ovl_q      <= '0;
      sd_n_q     <= 1'b1;
      otw_n_q    <= 1'b1;
    end else begin
      warn_q   <= warn_set_i | (warn_q & ~warn_clr_i);
      sup_uv_q <= sup_uv_set_i | (sup_uv_q & ~sup_uv_clr_i);
      bst_uv_q <= bst_uv_set_i | (bst_uv_q & ~bst_uv_clr_i);
      ovl_q    <= ovl_i | (ovl_q & pair_rst_n_i);
      if (err_set_i) begin
        ote_q      <= 1'b1;
        rst_seen_q <= '0;
      end else if (ote_q) begin
        if (&seen_now) begin
          ote_q      <= 1'b0;
          rst_seen_q <= '0;
        end else begin
          rst_seen_q <= seen_now;
        end
      end
      sd_n_q  <= ~fault_any | ~(&pair_rst_n_i);
      otw_n_q <= ~(warn_q | ote_q);
    end
  end

  // R8
  sd_mask_chk: assert property (@(posedge clk) disable iff (por_i)
    !(&$past(pair_rst_n_i)) |-> sd_n_o);

  // R5
  uv_hiz_chk: assert property (@(posedge clk) disable iff (por_i)
    ((|sup_uv_set_i) || (|bst_uv_set_i)) |-> (&hiz_o));

  // R3
  ote_status_chk: assert property (@(posedge clk) disable iff (por_i)
    err_set_i |=> ##1 (!otw_n_o && (&hiz_o)));

  // R11
  sd_lag_chk: assert property (@(posedge clk) disable iff (por_i)
    ($past(sd_n_o) && !$past(fault_any)) |-> sd_n_o);

  genvar p;
  generate
    for (p = 0; p < NPAIR; p++) begin : g_pair
      // R7
      ovl_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (ovl_i[p] && !err_set_i) |=> hiz_o[p]);
    end
  endgenerate

endmodule

// File: tb/fault_status_agg_test.sv
module fault_status_agg_test;
  localparam int PERIOD = 10;
  localparam int NPAIR = 2;
  localparam int NSUP = 5;
  localparam int NBST = 4;

  logic clk = 1'b0;
  logic por_i;
  logic warn_set_i, warn_clr_i, err_set_i;
  logic [NSUP-1:0] sup_uv_set_i, sup_uv_clr_i;
  logic [NBST-1:0] bst_uv_set_i, bst_uv_clr_i;
  logic [NPAIR-1:0] ovl_i, pair_rst_n_i;
  logic [NPAIR-1:0] hiz_o;
  logic sd_n_o, otw_n_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  fault_status_agg #(.NPAIR(NPAIR), .NSUP(NSUP), .NBST(NBST)) uut (
    .clk(clk), .por_i(por_i), .warn_set_i(warn_set_i), .warn_clr_i(warn_clr_i),
    .err_set_i(err_set_i), .sup_uv_set_i(sup_uv_set_i), .sup_uv_clr_i(sup_uv_clr_i),
    .bst_uv_set_i(bst_uv_set_i), .bst_uv_clr_i(bst_uv_clr_i), .ovl_i(ovl_i),
    .pair_rst_n_i(pair_rst_n_i), .hiz_o(hiz_o), .sd_n_o(sd_n_o), .otw_n_o(otw_n_o));

  // row: req[16:13] ws wc es us uc o0 o1 r0 r1 | sd otw h1 h0
  localparam logic [16:0] TBL [20] = '{
    17'b0001_0000000_11_1100, // R1 idle
    17'b0010_1000000_11_1000, // R2 warn set
    17'b0010_0000000_11_1000, // R2 held
    17'b0010_0100000_11_1100, // R2 release
    17'b0010_0000000_11_1100, // R2 stays released
    17'b0101_0001000_11_0111, // R5 uv rail 0
    17'b0110_0000000_11_0111, // R6 uv held
    17'b0101_0000100_11_1100, // R5 auto recover
    17'b0111_0000010_11_0101, // R7 overload pair 0
    17'b0111_0000000_11_0101, // R7 latched
    17'b1000_0000000_01_1101, // R8 pair reset masks sd
    17'b1000_0000000_11_1100, // R8 back to normal
    17'b1001_1000001_11_0010, // R9 warn + overload pair 1
    17'b1000_0100000_10_1110, // R8 reset pair 1
    17'b0011_0010000_11_0011, // R3 over-temp error
    17'b0011_0000000_11_0011, // R3 latched
    17'b0100_0000000_01_1011, // R4 first reset
    17'b0100_0000000_11_0011, // R4 one reset not enough
    17'b0100_0000000_10_1110, // R4 second reset clears
    17'b0100_0000000_11_1100  // R4 normal
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {sd,otw,hiz}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    warn_set_i = 0; warn_clr_i = 0; err_set_i = 0;
    sup_uv_set_i = '0; sup_uv_clr_i = '0;
    bst_uv_set_i = '0; bst_uv_clr_i = '0;
    ovl_i = '0; pair_rst_n_i = '1;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {sd_n_o, otw_n_o, hiz_o};
  endfunction

  initial begin
    #(PERIOD*50000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    por_i = 1;
    edges(3);
    chk("R1", outs(), 4'b1111);
    por_i = 0;
    edges(2);

    for (int i = 0; i < 20; i++) begin
      logic [16:0] r;
      r = TBL[i];
      warn_set_i = r[12]; warn_clr_i = r[11]; err_set_i = r[10];
      sup_uv_set_i = {{(NSUP-1){1'b0}}, r[9]};
      sup_uv_clr_i = {{(NSUP-1){1'b0}}, r[8]};
      ovl_i = {r[6], r[7]};
      pair_rst_n_i = {r[4], r[5]};
      edges(2);
      checks++;
      if (outs() !== r[3:0]) begin
        errors++;
        $display("FAIL R%0d row %0d: {sd,otw,hiz}=%b expected %b", r[16:13], i, outs(), r[3:0]);
      end
    end
    idle_inputs();
    edges(2);

    // R11 and R5: bootstrap rail, same-cycle Hi-Z, one-edge status lag
    bst_uv_set_i = 4'b0100;
    #1 chk("R5", outs(), 4'b1111);
    edges(1);
    chk("R11", outs(), 4'b1111);
    edges(1);
    chk("R11", outs(), 4'b0111);
    // R6 bootstrap hysteresis
    bst_uv_set_i = '0;
    edges(2);
    chk("R6", outs(), 4'b0111);
    bst_uv_clr_i = 4'b0100;
    edges(2);
    chk("R5", outs(), 4'b1100);
    idle_inputs();

    // R5 logic supply (last rail)
    sup_uv_set_i = 5'b10000;
    edges(2);
    chk("R5", outs(), 4'b0111);
    sup_uv_set_i = '0; sup_uv_clr_i = 5'b10000;
    edges(2);
    chk("R5", outs(), 4'b1100);
    idle_inputs();

    // R10 por clears overload latch
    ovl_i = 2'b10;
    edges(1);
    ovl_i = 2'b00;
    edges(2);
    chk("R7", outs(), 4'b0110);
    por_i = 1;
    #1 chk("R1", outs(), 4'b1111);
    edges(1);
    por_i = 0;
    edges(2);
    chk("R10", outs(), 4'b1100);

    // R3 same-cycle Hi-Z on error, then clear with both resets together
    err_set_i = 1;
    #1 chk("R3", {2'b11, hiz_o}, 4'b1111);
    edges(2);
    err_set_i = 0;
    pair_rst_n_i = 2'b00;
    edges(2);
    pair_rst_n_i = 2'b11;
    edges(2);
    chk("R4", outs(), 4'b1100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule